// File: doc/BRIEF.md
# Interpolator Blend and Clamp Result Stage

This block is the result stage of a two-lane interpolator. It accepts the shifted-and-masked value of each lane and three base words. It produces a lane 0 result, a lane 1 result and a combined result. The outputs are registered and are captured only when `in_valid` is high.

In the plain case each lane adds its own base, and the combined result adds both lane values to base 2. A build parameter can give one instance one alternate mode, and a run-time control bit then switches that mode on.

- **Blend variant.** Lane 1 forms a fractional interpolation between base 0 and base 1. The weight is an 8-bit value taken from lane 1's low bits. Lane 0 then returns that weight alone, and the combined result leaves out lane 1's value.
- **Clamp variant.** Lane 0's value is limited to a window whose lower bound is base 0 and whose upper bound is base 1. The comparison is signed or unsigned.

A control bit for a mode that the instance was not built with has no effect.

Top module: `blend_clamp_stage`

## Requirements
- R1: With no alternate mode active, lane0_res = base0 + sm0, lane1_res = base1 + sm1 and full_res = base2 + sm0 + sm1, each modulo 2^W.
- R2: Results and out_valid are registered. out_valid equals in_valid of the previous cycle. The three results change only in a cycle after in_valid was high, and otherwise hold their values.
- R3: Synchronous active-high reset clears out_valid and all three results to zero.
- R4: On the blend variant with blend_en=1, lane1_res = base0 + floor(((base1 - base0) * a) / 256), where a = sm1[7:0] read as an unsigned weight. A weight of 0 gives exactly base0.
- R5: In blend, sign1=1 treats both bases as two's complement. sign1=0 treats them as unsigned, and the difference may be negative.
- R6: In blend, lane0_res equals sm1[7:0] zero-extended to W bits. No base is added.
- R7: In blend, full_res = base2 + sm0. Lane 1's value is not added.
- R8: On the clamp variant with clamp_en=1 and sign0=0, lane0_res is sm0 bounded below by base0 and above by base1, compared as unsigned. lane1_res and full_res stay as in R1.
- R9: In clamp with sign0=1, the bound comparisons are two's-complement signed.
- R10: In clamp, the lower bound is applied first and the upper bound second. If base0 > base1, the result is therefore always base1.
- R11: blend_en has no effect on the clamp variant, and clamp_en has no effect on the blend variant. The outputs follow R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture inputs into the result registers |
| blend_en | input | 1 | Select blend (blend variant only) |
| clamp_en | input | 1 | Select clamp (clamp variant only) |
| sign0 | input | 1 | Signed comparison for the clamp |
| sign1 | input | 1 | Signed arithmetic for the blend |
| sm0 | input | W | Lane 0 shifted-and-masked value |
| sm1 | input | W | Lane 1 shifted-and-masked value |
| base0 | input | W | Base 0 / blend start / clamp lower bound |
| base1 | input | W | Base 1 / blend end / clamp upper bound |
| base2 | input | W | Base for the combined result |
| out_valid | output | 1 | Results updated last cycle |
| lane0_res | output | W | Lane 0 result |
| lane1_res | output | W | Lane 1 result |
| full_res | output | W | Combined result |

## Verification
The bench probes the blend where the signedness flag decides the outcome.

- **Signed against unsigned blend.** A pair of bases straddling zero gives 0 when treated as signed and 0x80000000 when treated as unsigned. A design that ignored sign1 would fail one of the two.
- **Rounding.** A signed difference of -1 at a weight of 1/256 must round down to -1, not up to 0. A design that truncated toward zero would return base0.
- **Clamp signedness.** A negative value is clamped to opposite bounds under the two signedness settings.
- **Inverted bounds.** The clamp is given base0 > base1, and a design that applied the bounds in the other order would return base0.
- **Ignored mode bit.** Each variant is driven with the other variant's bit set and must still produce the plain sums.
- **Held results.** The results are checked to hold while in_valid is low.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MODE_PLAIN = 0;
  localparam int MODE_BLEND = 1;
  localparam int MODE_CLAMP = 2;

  typedef enum logic [1:0] {
    SEL_PLAIN = 2'd0,
    SEL_BLEND = 2'd1,
    SEL_CLAMP = 2'd2
  } res_sel_e;
endpackage

// File: rtl/bcs_blend_unit.sv
module bcs_blend_unit #(
  parameter int W      = 32,
  parameter int FRAC_W = 8
) (
  input  logic [W-1:0]      lo_val,
  input  logic [W-1:0]      hi_val,
  input  logic [FRAC_W-1:0] weight,
  input  logic              is_signed,
  output logic [W-1:0]      mix
);
  localparam int DW = W + 2;
  localparam int PW = W + FRAC_W + 3;

  logic signed [W:0]    lo_ext, hi_ext;
  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] diff_w, wt_w, prod, scaled;

  always_comb begin
    lo_ext = is_signed ? $signed({lo_val[W-1], lo_val}) : $signed({1'b0, lo_val});
    hi_ext = is_signed ? $signed({hi_val[W-1], hi_val}) : $signed({1'b0, hi_val});
    diff   = DW'(hi_ext) - DW'(lo_ext);
    diff_w = $signed({{(PW-DW){diff[DW-1]}}, diff});
    wt_w   = $signed({{(PW-FRAC_W){1'b0}}, weight});
    prod   = diff_w * wt_w;
    scaled = prod >>> FRAC_W;
    mix    = lo_val + scaled[W-1:0];
  end
endmodule

// File: rtl/bcs_clamp_unit.sv
module bcs_clamp_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] floor_v,
  input  logic [W-1:0] ceil_v,
  input  logic         is_signed,
  output logic [W-1:0] bounded
);
  logic          below, above;
  logic [W-1:0]  after_lo;

  always_comb begin
    below    = is_signed ? ($signed(val) < $signed(floor_v)) : (val < floor_v);
    after_lo = below ? floor_v : val;
    above    = is_signed ? ($signed(after_lo) > $signed(ceil_v)) : (after_lo > ceil_v);
    bounded  = above ? ceil_v : after_lo;
  end
endmodule

// File: rtl/blend_clamp_stage.sv
module blend_clamp_stage
  import bcs_pkg::*;
#(
  parameter int W      = 32,
  parameter int FRAC_W = 8,
  parameter int MODE   = MODE_BLEND
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         blend_en,
  input  logic         clamp_en,
  input  logic         sign0,
  input  logic         sign1,
  input  logic [W-1:0] sm0,
  input  logic [W-1:0] sm1,
  input  logic [W-1:0] base0,
  input  logic [W-1:0] base1,
  input  logic [W-1:0] base2,
  output logic         out_valid,
  output logic [W-1:0] lane0_res,
  output logic [W-1:0] lane1_res,
  output logic [W-1:0] full_res
);
  logic [W-1:0] plain0, plain1, plainf, part_full;
  logic [W-1:0] alt0, alt1;
  res_sel_e     sel;
  logic [W-1:0] nxt0, nxt1, nxtf;

  always_comb begin
    plain0    = base0 + sm0;
    plain1    = base1 + sm1;
    part_full = base2 + sm0;
    plainf    = part_full + sm1;
  end

  generate
    if (MODE == MODE_BLEND) begin : g_blend
      logic [W-1:0] mix_w;
      bcs_blend_unit #(.W(W), .FRAC_W(FRAC_W)) u_blend (
        .lo_val   (base0),
        .hi_val   (base1),
        .weight   (sm1[FRAC_W-1:0]),
        .is_signed(sign1),
        .mix      (mix_w)
      );
      always_comb begin
        sel  = blend_en ? SEL_BLEND : SEL_PLAIN;
        alt0 = W'(sm1[FRAC_W-1:0]);
        alt1 = mix_w;
      end
    end else if (MODE == MODE_CLAMP) begin : g_clamp
      logic [W-1:0] bnd_w;
      bcs_clamp_unit #(.W(W)) u_clamp (
        .val      (sm0),
        .floor_v  (base0),
        .ceil_v   (base1),
        .is_signed(sign0),
        .bounded  (bnd_w)
      );
      always_comb begin
        sel  = clamp_en ? SEL_CLAMP : SEL_PLAIN;
        alt0 = bnd_w;
        alt1 = plain1;
      end
    end else begin : g_plain
      always_comb begin
        sel  = SEL_PLAIN;
        alt0 = plain0;
        alt1 = plain1;
      end
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_BLEND: begin nxt0 = alt0;   nxt1 = alt1;   nxtf = part_full; end
      SEL_CLAMP: begin nxt0 = alt0;   nxt1 = plain1; nxtf = plainf;    end
      default:   begin nxt0 = plain0; nxt1 = plain1; nxtf = plainf;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lane0_res <= '0;
      lane1_res <= '0;
      full_res  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lane0_res <= nxt0;
        lane1_res <= nxt1;
        full_res  <= nxtf;
      end
    end
  end
endmodule

// File: rtl/blend_clamp_stage_chk.sv
module blend_clamp_stage_chk
  import bcs_pkg::*;
#(
  parameter int W      = 32,
  parameter int FRAC_W = 8,
  parameter int MODE   = MODE_BLEND
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         blend_en,
  input logic         clamp_en,
  input logic         sign0,
  input logic [W-1:0] sm0,
  input logic [W-1:0] sm1,
  input logic [W-1:0] base0,
  input logic [W-1:0] base1,
  input logic         out_valid,
  input logic [W-1:0] lane0_res,
  input logic [W-1:0] lane1_res,
  input logic [W-1:0] full_res
);
  localparam bit IS_BLEND = (MODE == MODE_BLEND);
  localparam bit IS_CLAMP = (MODE == MODE_CLAMP);

  // R3
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && lane0_res == '0 && lane1_res == '0 && full_res == '0));

  // R2
  valid_track_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(lane0_res) && $stable(lane1_res) && $stable(full_res)));

  // R4
  zero_weight_chk: assert property (@(posedge clk) disable iff (rst)
    (IS_BLEND && in_valid && blend_en && sm1[FRAC_W-1:0] == '0) |=> lane1_res == $past(base0));

  // R6
  blend_lane0_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (IS_BLEND && in_valid && blend_en) |=> lane0_res[W-1:FRAC_W] == '0);

  // R8
  clamp_window_chk: assert property (@(posedge clk) disable iff (rst)
    (IS_CLAMP && in_valid && clamp_en && !sign0 && base0 <= base1)
      |=> (lane0_res >= $past(base0) && lane0_res <= $past(base1)));

  // R10
  inverted_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (IS_CLAMP && in_valid && clamp_en && !sign0 && base0 > base1) |=> lane0_res == $past(base1));

  // R11
  ignored_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (IS_CLAMP && in_valid && !clamp_en) |=> lane0_res == $past(base0 + sm0));
endmodule

bind blend_clamp_stage blend_clamp_stage_chk #(.W(W), .FRAC_W(FRAC_W), .MODE(MODE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .blend_en(blend_en), .clamp_en(clamp_en),
  .sign0(sign0), .sm0(sm0), .sm1(sm1), .base0(base0), .base1(base1),
  .out_valid(out_valid), .lane0_res(lane0_res), .lane1_res(lane1_res), .full_res(full_res)
);

// File: tb/test_blend_clamp_stage.sv
module test_blend_clamp_stage;
  import bcs_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int NV = 16;
  localparam int VW = 5 + 8 * W;

  // {use_clamp_inst, blend_en, clamp_en, sign0, sign1, sm0, sm1, b0, b1, b2, exp0, exp1, expf}
  localparam logic [VW-1:0] VECS [NV] = '{
    {5'b00000, 32'd5, 32'd7, 32'd100, 32'd200, 32'd1000, 32'd105, 32'd207, 32'd1012},
    {5'b01000, 32'd3, 32'h40, 32'd100, 32'd300, 32'd1000, 32'd64, 32'd150, 32'd1003},
    {5'b01000, 32'd0, 32'h100, 32'd1234, 32'd9999, 32'd0, 32'd0, 32'd1234, 32'd0},
    {5'b01000, 32'd1, 32'h80, 32'd300, 32'd100, 32'd1, 32'd128, 32'd200, 32'd2},
    {5'b01001, 32'd0, 32'h80, 32'hFFFFFF00, 32'h100, 32'd0, 32'd128, 32'd0, 32'd0},
    {5'b01000, 32'd0, 32'h80, 32'hFFFFFF00, 32'h100, 32'd0, 32'd128, 32'h80000000, 32'd0},
    {5'b01001, 32'd0, 32'h1, 32'd0, 32'hFFFFFFFF, 32'd0, 32'd1, 32'hFFFFFFFF, 32'd0},
    {5'b00100, 32'd5, 32'd7, 32'd10, 32'd20, 32'd0, 32'd15, 32'd27, 32'd12},
    {5'b10100, 32'd50, 32'd2, 32'd10, 32'd100, 32'd1000, 32'd50, 32'd102, 32'd1052},
    {5'b10100, 32'd5, 32'd2, 32'd10, 32'd100, 32'd1000, 32'd10, 32'd102, 32'd1007},
    {5'b10100, 32'd500, 32'd2, 32'd10, 32'd100, 32'd1000, 32'd100, 32'd102, 32'd1502},
    {5'b10110, 32'hFFFFFFF0, 32'd2, 32'hFFFFFFF6, 32'd20, 32'd1000, 32'hFFFFFFF6, 32'd22, 32'd986},
    {5'b10100, 32'hFFFFFFF0, 32'd2, 32'hFFFFFFF6, 32'd20, 32'd1000, 32'd20, 32'd22, 32'd986},
    {5'b10100, 32'd75, 32'd2, 32'd100, 32'd50, 32'd0, 32'd50, 32'd52, 32'd77},
    {5'b11000, 32'd5, 32'h40, 32'd100, 32'd300, 32'd0, 32'd105, 32'd364, 32'd69},
    {5'b10000, 32'd500, 32'd2, 32'd10, 32'd100, 32'd0, 32'd510, 32'd102, 32'd502}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";
      1: return "R4 R6 R7";
      2: return "R4 zero weight";
      3: return "R5 unsigned negative diff";
      4: return "R5 signed";
      5: return "R5 unsigned";
      6: return "R4 floor";
      7: return "R11 clamp_en on blend variant";
      8: return "R8 in window";
      9: return "R8 below";
      10: return "R8 above";
      11: return "R9 signed";
      12: return "R8 unsigned negative";
      13: return "R10";
      14: return "R11 blend_en on clamp variant";
      default: return "R1 clamp variant plain";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, blend_en = 1'b0, clamp_en = 1'b0, sign0 = 1'b0, sign1 = 1'b0;
  logic [W-1:0] sm0 = '0, sm1 = '0, base0 = '0, base1 = '0, base2 = '0;
  logic         ov_b, ov_c;
  logic [W-1:0] l0_b, l1_b, f_b, l0_c, l1_c, f_c;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blend_clamp_stage #(.W(W), .FRAC_W(8), .MODE(MODE_BLEND)) i_blend_clamp_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .blend_en(blend_en), .clamp_en(clamp_en),
    .sign0(sign0), .sign1(sign1), .sm0(sm0), .sm1(sm1), .base0(base0), .base1(base1),
    .base2(base2), .out_valid(ov_b), .lane0_res(l0_b), .lane1_res(l1_b), .full_res(f_b));

  blend_clamp_stage #(.W(W), .FRAC_W(8), .MODE(MODE_CLAMP)) i_blend_clamp_stage_clamp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .blend_en(blend_en), .clamp_en(clamp_en),
    .sign0(sign0), .sign1(sign1), .sm0(sm0), .sm1(sm1), .base0(base0), .base1(base1),
    .base2(base2), .out_valid(ov_c), .lane0_res(l0_c), .lane1_res(l1_c), .full_res(f_c));

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: reset state
    check("R3 out_valid", {31'd0, ov_b}, 32'd0);
    check("R3 lane0", l0_b, '0);
    check("R3 lane1", l1_c, '0);
    check("R3 full", f_c, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      @(negedge clk);
      {blend_en, clamp_en, sign0, sign1} = v[VW-2 -: 4];
      sm0   = v[8*W-1 -: W];
      sm1   = v[7*W-1 -: W];
      base0 = v[6*W-1 -: W];
      base1 = v[5*W-1 -: W];
      base2 = v[4*W-1 -: W];
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (v[VW-1]) begin
        check({tag_of(i), " lane0"}, l0_c, v[3*W-1 -: W]);
        check({tag_of(i), " lane1"}, l1_c, v[2*W-1 -: W]);
        check({tag_of(i), " full"},  f_c,  v[W-1 -: W]);
      end else begin
        check({tag_of(i), " lane0"}, l0_b, v[3*W-1 -: W]);
        check({tag_of(i), " lane1"}, l1_b, v[2*W-1 -: W]);
        check({tag_of(i), " full"},  f_b,  v[W-1 -: W]);
      end
    end

    // R2: valid high yields out_valid; low input holds results
    @(negedge clk);
    {blend_en, clamp_en} = 2'b00;
    sm0 = 32'd1; sm1 = 32'd2; base0 = 32'd3; base1 = 32'd4; base2 = 32'd5;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 out_valid high", {31'd0, ov_b}, 32'd1);
    check("R2 lane0 captured", l0_b, 32'd4);
    in_valid = 1'b0;
    sm0 = 32'd100; base0 = 32'd200;
    @(posedge clk); @(negedge clk);
    check("R2 out_valid low", {31'd0, ov_b}, 32'd0);
    check("R2 lane0 held", l0_b, 32'd4);
    check("R2 full held", f_b, 32'd8);

    // R3: reset after activity
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 lane0 after reset", l0_b, '0);
    check("R3 lane1 after reset", l1_b, '0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule